// File: doc/BRIEF.md
# Address Translation Sequencer with Page Protection Check

This block takes one address translation request at a time and turns it into a final outcome. An outcome is either a real address with an access level, or a storage fault. The request carries an effective address, a flag that marks an instruction fetch, a write flag, and a flag that suppresses faults. When the translation enable for the request's kind (fetch or data) is off, the effective address passes straight through with read-write access.

Otherwise the block asks the block-translation lookup first. A hit that grants any access finishes the request at once. On a miss, the block asks the page-table lookup. It then chooses a protection key from the segment's user-key or supervisor-key bit, according to the privilege level. With that key it decodes the page protection field, denies fetches from no-execute segments or guarded pages, and forms the real address from the page number in the entry.

A failed data access loads a fault address register and a fault status register. A failed fetch raises an instruction fault and leaves those registers alone. The lookup units themselves sit outside this block. They are started by one-cycle request pulses and reply with a valid strobe.

Top module: `xlat_ctrl`

## Requirements
- R1: When `req_is_fetch`=1 and `xlat_fetch_en`=0, or when `req_is_fetch`=0 and `xlat_data_en`=0, the request completes with `done_o` in the cycle after acceptance. In that case `pa_o` equals the request address, `lvl_o`=2 (read-write), and no lookup is started.
- R2: When the block lookup reports a hit with `blk_access` nonzero, the request completes with `pa_o`=`blk_paddr` and `lvl_o`=`blk_access`, and no page lookup is started.
- R3: When the block lookup reports a hit with `blk_access`=0, the result is a protection failure, and no page lookup is started.
- R4: When the block lookup misses, exactly one `pg_req_o` pulse is issued. A page lookup miss is a not-found failure.
- R5: The protection key equals `seg_ukey` when `user_mode`=1 and equals `seg_skey` when `user_mode`=0.
- R6: With the key set, the protection field `pg_low[1:0]` decodes as follows: 0 gives no access (a protection failure), 1 and 3 give read-only (`lvl_o`=1), and 2 gives read-write (`lvl_o`=2).
- R7: With the key clear, a protection field of 3 gives read-only and every other value gives read-write.
- R8: A write to a page whose decoded level is read-only is a protection failure.
- R9: A fetch is a protection failure when `seg_noexec`=1 or the guarded bit `pg_low[3]`=1, even when the entry matches.
- R10: On a page-table success, `pa_o` = {`pg_low[31:12]`, request address[11:0]}.
- R11: A data failure pulses `fault_o` with `fault_instr_o`=0 and loads `far_o` with the request address. It also loads `fsr_o` with bit 30 for not-found or bit 27 for protection, ORed with bit 25 for a write; all other bits are zero. An instruction failure pulses `fault_o` with `fault_instr_o`=1 and leaves `far_o` and `fsr_o` unchanged.
- R12: A failure on a request with `req_no_fault`=1 completes with `done_o`, `lvl_o`=0 and no `fault_o`, and leaves `far_o` and `fsr_o` unchanged.
- R13: Each accepted request produces exactly one single-cycle pulse, on either `done_o` or `fault_o`. `req_ready` is high only when no request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Idle, able to accept a request |
| req_addr | input | 32 | Effective address |
| req_is_fetch | input | 1 | 1 for instruction fetch, 0 for data |
| req_is_write | input | 1 | Data store |
| req_no_fault | input | 1 | Suppress fault on failure |
| xlat_fetch_en | input | 1 | Instruction translation enabled |
| xlat_data_en | input | 1 | Data translation enabled |
| user_mode | input | 1 | Privilege level, 1 = user |
| blk_req_o | output | 1 | Start pulse for block lookup |
| blk_rsp_valid | input | 1 | Block lookup result valid |
| blk_hit | input | 1 | Block lookup hit |
| blk_access | input | 2 | Block access level, 0 none, 1 read-only, 2 read-write |
| blk_paddr | input | 32 | Block-translated address |
| pg_req_o | output | 1 | Start pulse for page lookup |
| pg_rsp_valid | input | 1 | Page lookup result valid |
| pg_hit | input | 1 | Page entry found |
| pg_low | input | 32 | Entry low word: [31:12] page number, [3] guarded, [1:0] protection |
| seg_noexec | input | 1 | Segment no-execute bit |
| seg_ukey | input | 1 | Segment user-key bit |
| seg_skey | input | 1 | Segment supervisor-key bit |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Storage fault pulse |
| fault_instr_o | output | 1 | Last fault was an instruction fault |
| pa_o | output | 32 | Real address of the last completion |
| lvl_o | output | 2 | Access level of the last completion |
| far_o | output | 32 | Fault address register |
| fsr_o | output | 32 | Fault status register |

## Verification
The assertions assume that the lookup result buses are stable and meaningful in any cycle where their valid strobe is high while the block waits for that lookup. They also assume that a valid strobe seen while the block is not waiting carries no meaning. The bench keeps both lookup units' results valid and held before each request is issued. The only exception is the stall scenario, where a strobe is raised late, and it changes only the strobe. Request fields are driven only while `req_ready` is high and are dropped one cycle after acceptance.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RO   = 2'd1,
    ACC_RW   = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_BLK  = 2'd1,
    S_PG   = 2'd2
  } xstate_e;

  localparam int FSR_W         = 32;
  localparam int FSR_NOTFOUND  = 30;
  localparam int FSR_PROTECT   = 27;
  localparam int FSR_STORE     = 25;
  localparam int PTE_GUARD_BIT = 3;
endpackage

// File: rtl/xlat_prot_eval.sv
module xlat_prot_eval
  import xlat_pkg::*;
(
  input  logic       user_mode,
  input  logic       seg_ukey,
  input  logic       seg_skey,
  input  logic       seg_noexec,
  input  logic       guarded,
  input  logic [1:0] pp,
  input  logic       is_fetch,
  input  logic       is_write,
  output acc_e       lvl,
  output logic       deny
);
  logic key;
  acc_e base;

  always_comb begin
    key = user_mode ? seg_ukey : seg_skey;
    if (key) begin
      unique case (pp)
        2'd0:    base = ACC_NONE;
        2'd2:    base = ACC_RW;
        default: base = ACC_RO;
      endcase
    end else begin
      base = (pp == 2'd3) ? ACC_RO : ACC_RW;
    end
    deny = (base == ACC_NONE)
         || (is_write && base == ACC_RO)
         || (is_fetch && (seg_noexec || guarded));
    lvl  = deny ? ACC_NONE : base;
  end
endmodule

// File: rtl/xlat_fault_regs.sv
module xlat_fault_regs
  import xlat_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             not_found_i,
  input  logic             store_i,
  output logic [AW-1:0]    far_o,
  output logic [FSR_W-1:0] fsr_o
);
  logic [AW-1:0]    far_d;
  logic [FSR_W-1:0] fsr_d;

  always_comb begin
    far_d = addr_i;
    fsr_d = '0;
    if (not_found_i) fsr_d[FSR_NOTFOUND] = 1'b1;
    else             fsr_d[FSR_PROTECT]  = 1'b1;
    fsr_d[FSR_STORE] = store_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      far_o <= '0;
      fsr_o <= '0;
    end else if (load_i) begin
      far_o <= far_d;
      fsr_o <= fsr_d;
    end
  end

  // R12 / R11: registers change only on a load
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(far_o) && $stable(fsr_o)));
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFS_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_is_fetch,
  input  logic          req_is_write,
  input  logic          req_no_fault,
  input  logic          xlat_fetch_en,
  input  logic          xlat_data_en,
  input  logic          user_mode,
  output logic          blk_req_o,
  input  logic          blk_rsp_valid,
  input  logic          blk_hit,
  input  logic [1:0]    blk_access,
  input  logic [AW-1:0] blk_paddr,
  output logic          pg_req_o,
  input  logic          pg_rsp_valid,
  input  logic          pg_hit,
  input  logic [AW-1:0] pg_low,
  input  logic          seg_noexec,
  input  logic          seg_ukey,
  input  logic          seg_skey,
  output logic          done_o,
  output logic          fault_o,
  output logic          fault_instr_o,
  output logic [AW-1:0] pa_o,
  output logic [1:0]    lvl_o,
  output logic [AW-1:0] far_o,
  output logic [31:0]   fsr_o
);
  localparam int RPN_W = AW - OFS_W;

  xstate_e       state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          fetch_q, write_q, nof_q;
  logic          cap_en;
  logic          blk_req_d, pg_req_d;
  logic          fin, fin_ok, fin_nf;
  logic [AW-1:0] fin_pa;
  acc_e          fin_lvl;
  logic          bypass;
  acc_e          pg_lvl;
  logic          pg_deny;
  logic          fault_d, done_d, load_regs;
  logic [RPN_W-1:0] rpn;

  assign rpn = pg_low[AW-1:OFS_W];

  xlat_prot_eval u_prot (
    .user_mode (user_mode),
    .seg_ukey  (seg_ukey),
    .seg_skey  (seg_skey),
    .seg_noexec(seg_noexec),
    .guarded   (pg_low[PTE_GUARD_BIT]),
    .pp        (pg_low[1:0]),
    .is_fetch  (fetch_q),
    .is_write  (write_q),
    .lvl       (pg_lvl),
    .deny      (pg_deny)
  );

  always_comb begin
    bypass    = req_is_fetch ? !xlat_fetch_en : !xlat_data_en;
    state_d   = state_q;
    cap_en    = 1'b0;
    blk_req_d = 1'b0;
    pg_req_d  = 1'b0;
    fin       = 1'b0;
    fin_ok    = 1'b0;
    fin_nf    = 1'b0;
    fin_pa    = '0;
    fin_lvl   = ACC_NONE;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        cap_en = 1'b1;
        if (bypass) begin
          fin     = 1'b1;
          fin_ok  = 1'b1;
          fin_pa  = req_addr;
          fin_lvl = ACC_RW;
        end else begin
          state_d   = S_BLK;
          blk_req_d = 1'b1;
        end
      end
      S_BLK: if (blk_rsp_valid) begin
        if (blk_hit) begin
          fin = 1'b1;
          if (blk_access != 2'd0) begin
            fin_ok  = 1'b1;
            fin_pa  = blk_paddr;
            fin_lvl = acc_e'(blk_access);
          end
        end else begin
          state_d  = S_PG;
          pg_req_d = 1'b1;
        end
      end
      S_PG: if (pg_rsp_valid) begin
        fin = 1'b1;
        if (!pg_hit) begin
          fin_nf = 1'b1;
        end else if (!pg_deny) begin
          fin_ok  = 1'b1;
          fin_pa  = {rpn, addr_q[OFS_W-1:0]};
          fin_lvl = pg_lvl;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
    // a bypass finishes in IDLE, where the captured flags are not yet valid
    done_d    = fin && (fin_ok || (state_q != S_IDLE && nof_q));
    fault_d   = fin && !fin_ok && state_q != S_IDLE && !nof_q;
    load_regs = fault_d && !fetch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      addr_q        <= '0;
      fetch_q       <= 1'b0;
      write_q       <= 1'b0;
      nof_q         <= 1'b0;
      blk_req_o     <= 1'b0;
      pg_req_o      <= 1'b0;
      done_o        <= 1'b0;
      fault_o       <= 1'b0;
      fault_instr_o <= 1'b0;
      pa_o          <= '0;
      lvl_o         <= ACC_NONE;
    end else begin
      state_q   <= state_d;
      blk_req_o <= blk_req_d;
      pg_req_o  <= pg_req_d;
      done_o    <= done_d;
      fault_o   <= fault_d;
      if (cap_en) begin
        addr_q  <= req_addr;
        fetch_q <= req_is_fetch;
        write_q <= req_is_write;
        nof_q   <= req_no_fault;
      end
      if (fin) begin
        pa_o  <= fin_pa;
        lvl_o <= fin_lvl;
      end
      if (fault_d) fault_instr_o <= fetch_q;
    end
  end

  assign req_ready = (state_q == S_IDLE);

  xlat_fault_regs #(.AW(AW)) u_fregs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_regs),
    .addr_i     (addr_q),
    .not_found_i(fin_nf),
    .store_i    (write_q),
    .far_o      (far_o),
    .fsr_o      (fsr_o)
  );

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && (req_is_fetch ? !xlat_fetch_en : !xlat_data_en))
    |=> (done_o && lvl_o == 2'd2 && pa_o == $past(req_addr) && !blk_req_o));

  p_blk_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BLK && blk_rsp_valid && blk_hit && blk_access != 2'd0)
    |=> (done_o && !pg_req_o && pa_o == $past(blk_paddr)));

  p_pg_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req_o |=> !pg_req_o);

  p_fsr_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !fault_instr_o) |-> (fsr_o[FSR_NOTFOUND] != fsr_o[FSR_PROTECT]));

  p_one_outcome_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));

  p_ready_after_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fault_o) |-> req_ready);
endmodule

// File: tb/tb_xlat_ctrl.sv
`timescale 1ns/1ps
module tb_xlat_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_is_fetch, req_is_write, req_no_fault;
  logic [31:0] req_addr;
  logic        req_ready;
  logic        xlat_fetch_en, xlat_data_en, user_mode;
  logic        blk_req_o, blk_rsp_valid, blk_hit;
  logic [1:0]  blk_access;
  logic [31:0] blk_paddr;
  logic        pg_req_o, pg_rsp_valid, pg_hit;
  logic [31:0] pg_low;
  logic        seg_noexec, seg_ukey, seg_skey;
  logic        done_o, fault_o, fault_instr_o;
  logic [31:0] pa_o, far_o, fsr_o;
  logic [1:0]  lvl_o;

  int n_chk = 0, n_bad = 0, pg_cnt = 0, blk_cnt = 0, cyc = 0;
  logic got_done, got_fault;

  localparam logic [31:0] NF = 32'h1 << 30;
  localparam logic [31:0] PR = 32'h1 << 27;
  localparam logic [31:0] ST = 32'h1 << 25;

  always #2.5 clk = ~clk;

  xlat_ctrl dut (.*);

  always @(negedge clk) begin
    if (pg_req_o)  pg_cnt++;
    if (blk_req_o) blk_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] a, input logic f, input logic w, input logic nf);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_fetch = f; req_is_write = w; req_no_fault = nf;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (done_o || fault_o) break;
      @(negedge clk);
    end
    got_done = done_o; got_fault = fault_o;
    chk("R13 one outcome", {31'b0, done_o ^ fault_o}, 32'd1);
    @(negedge clk);
    chk("R13 single cycle", {30'b0, done_o, fault_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R13 reset ready", {31'b0, req_ready}, 32'd1);
    chk("R13 reset pulses", {30'b0, done_o, fault_o}, 32'd0);
    chk("R11 reset far", far_o, 32'd0);
    chk("R11 reset fsr", fsr_o, 32'd0);
  endtask

  task automatic t_bypass();
    int b0 = blk_cnt;
    xlat_fetch_en = 1'b1; xlat_data_en = 1'b0;
    run_req(32'hCAFE_1234, 1'b0, 1'b1, 1'b0);
    chk("R1 data bypass done", {31'b0, got_done}, 32'd1);
    chk("R1 data bypass pa", pa_o, 32'hCAFE_1234);
    chk("R1 data bypass lvl", {30'b0, lvl_o}, 32'd2);
    xlat_fetch_en = 1'b0; xlat_data_en = 1'b1;
    run_req(32'h0000_8ABC, 1'b1, 1'b0, 1'b0);
    chk("R1 fetch bypass pa", pa_o, 32'h0000_8ABC);
    chk("R1 no lookup", blk_cnt - b0, 32'd0);
    xlat_fetch_en = 1'b1; xlat_data_en = 1'b1;
  endtask

  task automatic t_block();
    int p0 = pg_cnt;
    blk_hit = 1'b1; blk_access = 2'd1; blk_paddr = 32'h7700_0042;
    run_req(32'h1000_0042, 1'b0, 1'b0, 1'b0);
    chk("R2 blk done", {31'b0, got_done}, 32'd1);
    chk("R2 blk pa", pa_o, 32'h7700_0042);
    chk("R2 blk lvl", {30'b0, lvl_o}, 32'd1);
    chk("R2 no page search", pg_cnt - p0, 32'd0);
    blk_access = 2'd0;
    run_req(32'h2000_0010, 1'b0, 1'b1, 1'b0);
    chk("R3 blk deny fault", {31'b0, got_fault}, 32'd1);
    chk("R3 fsr", fsr_o, PR | ST);
    chk("R11 far", far_o, 32'h2000_0010);
    chk("R3 no page search", pg_cnt - p0, 32'd0);
    blk_hit = 1'b0;
  endtask

  task automatic t_page_miss();
    int p0 = pg_cnt;
    pg_hit = 1'b0;
    run_req(32'h3333_4444, 1'b0, 1'b0, 1'b0);
    chk("R4 miss fault", {31'b0, got_fault}, 32'd1);
    chk("R4 one page req", pg_cnt - p0, 32'd1);
    chk("R11 nf fsr", fsr_o, NF);
    chk("R11 nf far", far_o, 32'h3333_4444);
    chk("R11 data kind", {31'b0, fault_instr_o}, 32'd0);
    pg_hit = 1'b1;
  endtask

  task automatic t_keys();
    for (int c = 0; c < 32; c++) begin
      logic u, uk, sk, key;
      logic [1:0] pp, el;
      logic [31:0] a;
      u = c[4]; uk = c[3]; sk = c[2]; pp = c[1:0];
      user_mode = u; seg_ukey = uk; seg_skey = sk;
      pg_low = {20'hA5000 + 20'(c), 8'h0, 2'b00, pp};
      key = u ? uk : sk;  // R5
      if (key) el = (pp == 2'd0) ? 2'd0 : (pp == 2'd2) ? 2'd2 : 2'd1;  // R6
      else     el = (pp == 2'd3) ? 2'd1 : 2'd2;                        // R7
      a = {12'h0, 8'(c), 12'hABC};
      run_req(a, 1'b0, 1'b0, 1'b0);
      if (el == 2'd0) begin
        chk("R6 no access fault", {31'b0, got_fault}, 32'd1);
        chk("R6 fsr protect", fsr_o, PR);
      end else begin
        chk("R5 R6 R7 level", {30'b0, lvl_o}, {30'b0, el});
        chk("R10 real addr", pa_o, {20'hA5000 + 20'(c), 12'hABC});
      end
    end
    user_mode = 1'b0; seg_ukey = 1'b0; seg_skey = 1'b0;
  endtask

  task automatic t_write_ro();
    pg_low = 32'h1234_5003;
    run_req(32'h0BAD_0F00, 1'b0, 1'b1, 1'b0);
    chk("R8 write ro fault", {31'b0, got_fault}, 32'd1);
    chk("R8 fsr", fsr_o, PR | ST);
    pg_low = 32'h1234_5002;
    run_req(32'h0BAD_0F00, 1'b0, 1'b1, 1'b0);
    chk("R8 write rw ok", {31'b0, got_done}, 32'd1);
    chk("R8 rw pa", pa_o, 32'h1234_5F00);
  endtask

  task automatic t_fetch();
    logic [31:0] far0, fsr0;
    far0 = far_o; fsr0 = fsr_o;
    pg_low = 32'h4444_4002; seg_noexec = 1'b1;
    run_req(32'h5000_0100, 1'b1, 1'b0, 1'b0);
    chk("R9 noexec fault", {31'b0, got_fault}, 32'd1);
    chk("R11 instr kind", {31'b0, fault_instr_o}, 32'd1);
    chk("R11 instr far kept", far_o, far0);
    chk("R11 instr fsr kept", fsr_o, fsr0);
    seg_noexec = 1'b0; pg_low = 32'h4444_400A;
    run_req(32'h5000_0100, 1'b1, 1'b0, 1'b0);
    chk("R9 guarded fault", {31'b0, got_fault}, 32'd1);
    pg_low = 32'h4444_4002;
    run_req(32'h5000_0100, 1'b1, 1'b0, 1'b0);
    chk("R9 plain fetch ok", pa_o, 32'h4444_4100);
  endtask

  task automatic t_nofault();
    logic [31:0] far0, fsr0;
    far0 = far_o; fsr0 = fsr_o;
    pg_hit = 1'b0;
    run_req(32'h6666_0000, 1'b0, 1'b1, 1'b1);
    chk("R12 done not fault", {30'b0, got_done, got_fault}, 32'd2);
    chk("R12 lvl none", {30'b0, lvl_o}, 32'd0);
    chk("R12 far kept", far_o, far0);
    chk("R12 fsr kept", fsr_o, fsr0);
    pg_hit = 1'b1;
  endtask

  task automatic t_stall();
    blk_rsp_valid = 1'b0;
    pg_low = 32'h9999_9002;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_0777; req_is_fetch = 1'b0;
    req_is_write = 1'b0; req_no_fault = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R13 busy not ready", {31'b0, req_ready}, 32'd0);
    chk("R13 no early outcome", {30'b0, done_o, fault_o}, 32'd0);
    blk_rsp_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R13 done after stall", {31'b0, done_o}, 32'd1);
    chk("R10 stall pa", pa_o, 32'h9999_9777);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_is_fetch = 1'b0;
    req_is_write = 1'b0; req_no_fault = 1'b0;
    xlat_fetch_en = 1'b1; xlat_data_en = 1'b1; user_mode = 1'b0;
    blk_rsp_valid = 1'b1; blk_hit = 1'b0; blk_access = 2'd0; blk_paddr = '0;
    pg_rsp_valid = 1'b1; pg_hit = 1'b1; pg_low = '0;
    seg_noexec = 1'b0; seg_ukey = 1'b0; seg_skey = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_block();
    t_page_miss();
    t_keys();
    t_write_ro();
    t_fetch();
    t_nofault();
    t_stall();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule